// File: doc/BRIEF.md
# Wide Memory Indirect Access Sequencer

This block carries out a single 128-bit read or write to a backing memory that the chip can reach only through a small bank of 32-bit indirect registers. Every register in that bank is reached in the same way. The block writes the register's address into a window register and reads the window back until it holds that address. Only then does it access a shared data port. The sequencer builds the whole 128-bit transaction from these confirmed indirect accesses: it programs a 64-bit address, arms the memory controller, loads or fetches four data words, and polls a busy bit until the controller finishes.

A requester presents a 64-bit address, a read/write flag and four write words, then pulses `start` while `idle` is high. At the end the block pulses `done` for one cycle. On a read that succeeds it returns the four words on `rdData`. On any failure it raises `err` with a code that names the failing step, and it sets a sticky recovery request that only reset clears.

Top module: `wmem_seq`

## Requirements
- R1: Before each data-port access (bus address `DATA_PORT_ADDR`), the target register's address is written to the window register (bus address `WIN_REG_ADDR`) and read back until it matches. At most `WIN_TRIES` (default 100) read-backs are allowed, and the data port is never touched before a match.
- R2: If none of the allowed read-backs matches, the transaction ends at once with `err` = 1, `recoveryReq` = 1 and `stepCode` naming the access that was being set up.
- R3: Every transaction begins with three indirect writes in this order: the address low word to target `REG_BASE+0x0`, the address high word to `REG_BASE+0x4`, then 0x2 to the control register at `REG_BASE+0x8`.
- R4: A write then loads the write words to `REG_BASE+0x10/0x14/0x18/0x1C`, with bits 31:0 first and 127:96 last, and then writes 0x7 to the control register.
- R5: A read writes 0x3 to the control register. Once busy clears, it reads `REG_BASE+0x20/0x24/0x28/0x2C` in that order into `rdData` bits 31:0, 63:32, 95:64 and 127:96.
- R6: After the command, the control register is read until bit 3 (busy) is 0. Each poll is a full confirmed indirect read. If `POLL_TRIES` (default 100) polls all show busy, the transaction fails with step code 15.
- R7: `stepCode` on failure is 1 for the address low write, 2 for the address high write, 3 for the 0x2 control write, 4 to 7 for write words 0 to 3, 8 for the 0x7 control write, 9 for the 0x3 control write, 10 for a control poll read, 11 to 14 for read words 0 to 3, and 15 for the busy timeout. It is 0 on success.
- R8: Once set, `recoveryReq` stays at 1 through later transactions, including ones that succeed, until reset.
- R9: `start` is accepted only while `idle` is 1. A pulse during a transaction has no effect on that transaction or on the memory.
- R10: `done` is a one-cycle pulse on success and on failure. `err` and `stepCode` are valid with it and are held until the next accepted start.
- R11: After reset: `idle` = 1, `done` = 0, `err` = 0, `stepCode` = 0, `recoveryReq` = 0, `busEn` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqAddr | input | 64 | Memory address |
| reqWrData | input | 128 | Write data, word 0 in bits 31:0 |
| idle | output | 1 | Ready to accept a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last transaction failed |
| stepCode | output | 4 | Failing step, 0 on success |
| recoveryReq | output | 1 | Sticky recovery request |
| rdData | output | 128 | Read result |
| busEn | output | 1 | Register bus access strobe |
| busWe | output | 1 | Register bus write |
| busAddr | output | 32 | Register bus address |
| busWdata | output | 32 | Register bus write data |
| busRdata | input | 32 | Register bus read data, valid the cycle after a read |

## Verification
On every cycle, the checker confirms that no data-port access happens without a window read-back that returned the address just programmed. It also checks that `done` lasts one cycle, that `err` on completion matches a nonzero step code, that a failure always leaves the recovery request set and that the request never drops, and that the bus stays quiet while idle. The order of the indirect writes, the control codes 0x2, 0x7 and 0x3, the read word order and the exact step code of each failure point can only be shown by the bench's register model. The same holds for the 100-try limits on window and busy polling, checked at 99 and at 100, and for a start pulse that arrives mid-transaction and must be ignored.

// File: rtl/wmem_pkg.sv
package wmem_pkg;

  localparam logic [3:0] STEP_NONE  = 4'd0;
  localparam logic [3:0] STEP_ALO   = 4'd1;
  localparam logic [3:0] STEP_AHI   = 4'd2;
  localparam logic [3:0] STEP_ARM   = 4'd3;
  localparam logic [3:0] STEP_WD0   = 4'd4;
  localparam logic [3:0] STEP_WD3   = 4'd7;
  localparam logic [3:0] STEP_GOWR  = 4'd8;
  localparam logic [3:0] STEP_GORD  = 4'd9;
  localparam logic [3:0] STEP_POLL  = 4'd10;
  localparam logic [3:0] STEP_RD0   = 4'd11;
  localparam logic [3:0] STEP_RD3   = 4'd14;
  localparam logic [3:0] STEP_BUSYTO = 4'd15;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadReq;
    logic       busEn;
    logic       busWin;
    logic       busWrite;
    logic       clrTry;
    logic       incTry;
    logic       clrPoll;
    logic       incPoll;
    logic       capWord;
    logic       finish;
    logic       failed;
    logic [3:0] failCode;
  } ctlT;

  // step that follows s; STEP_NONE means the transaction is complete
  function automatic logic [3:0] nextStep(input logic [3:0] s, input logic isRd);
    case (s)
      STEP_ALO:  nextStep = STEP_AHI;
      STEP_AHI:  nextStep = STEP_ARM;
      STEP_ARM:  nextStep = isRd ? STEP_GORD : STEP_WD0;
      STEP_WD3:  nextStep = STEP_GOWR;
      STEP_GOWR: nextStep = STEP_POLL;
      STEP_GORD: nextStep = STEP_POLL;
      STEP_POLL: nextStep = isRd ? STEP_RD0 : STEP_NONE;
      STEP_RD3:  nextStep = STEP_NONE;
      default:   nextStep = (s == STEP_NONE) ? STEP_NONE : s + 4'd1;
    endcase
  endfunction

  function automatic logic stepIsWrite(input logic [3:0] s);
    stepIsWrite = (s != STEP_NONE) && (s <= STEP_GORD);
  endfunction

endpackage

// File: rtl/wmem_ctrl.sv
module wmem_ctrl
  import wmem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       isRead,
  input  logic       winMatch,
  input  logic       winLast,
  input  logic       busyBit,
  input  logic       pollLast,
  output ctlT        ctl,
  output logic [3:0] step,
  output logic       idle,
  output logic       done
);

  typedef enum logic [2:0] {
    S_IDLE, S_WIN_WR, S_WIN_RD, S_WIN_CHK, S_DATA, S_DATA_CHK, S_FIN
  } stateT;

  stateT      state, nState;
  logic [3:0] nStep;
  logic [3:0] follow;

  assign follow = nextStep(step, isRead);

  always_comb begin
    ctl    = '0;
    nState = state;
    nStep  = step;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctl.loadReq = 1'b1;
          ctl.clrPoll = 1'b1;
          nStep       = STEP_ALO;
          nState      = S_WIN_WR;
        end
      end
      S_WIN_WR: begin
        ctl.busEn    = 1'b1;
        ctl.busWin   = 1'b1;
        ctl.busWrite = 1'b1;
        ctl.clrTry   = 1'b1;
        nState       = S_WIN_RD;
      end
      S_WIN_RD: begin
        ctl.busEn  = 1'b1;
        ctl.busWin = 1'b1;
        nState     = S_WIN_CHK;
      end
      S_WIN_CHK: begin
        if (winMatch) begin
          nState = S_DATA;
        end else if (winLast) begin
          ctl.finish   = 1'b1;
          ctl.failed   = 1'b1;
          ctl.failCode = step;
          nState       = S_FIN;
        end else begin
          ctl.incTry = 1'b1;
          nState     = S_WIN_RD;
        end
      end
      S_DATA: begin
        ctl.busEn    = 1'b1;
        ctl.busWrite = stepIsWrite(step);
        if (stepIsWrite(step)) begin
          nStep  = follow;
          nState = S_WIN_WR;
        end else begin
          nState = S_DATA_CHK;
        end
      end
      S_DATA_CHK: begin
        if (step == STEP_POLL) begin
          if (!busyBit) begin
            nStep = follow;
            if (follow == STEP_NONE) begin
              ctl.finish = 1'b1;
              nState     = S_FIN;
            end else begin
              nState = S_WIN_WR;
            end
          end else if (pollLast) begin
            ctl.finish   = 1'b1;
            ctl.failed   = 1'b1;
            ctl.failCode = STEP_BUSYTO;
            nState       = S_FIN;
          end else begin
            ctl.incPoll = 1'b1;
            nState      = S_WIN_WR;
          end
        end else begin
          ctl.capWord = 1'b1;
          nStep       = follow;
          if (follow == STEP_NONE) begin
            ctl.finish = 1'b1;
            nState     = S_FIN;
          end else begin
            nState = S_WIN_WR;
          end
        end
      end
      S_FIN: begin
        nState = S_IDLE;
      end
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      step  <= STEP_NONE;
    end else begin
      state <= nState;
      step  <= nStep;
    end
  end

  assign idle = (state == S_IDLE);
  assign done = (state == S_FIN);

endmodule

// File: rtl/wmem_dpath.sv
module wmem_dpath
  import wmem_pkg::*;
#(
  parameter int          ADDR_W         = 64,
  parameter int          WORD_W         = 32,
  parameter int          WIN_TRIES      = 100,
  parameter int          POLL_TRIES     = 100,
  parameter int          BUSY_BIT       = 3,
  parameter logic [31:0] WIN_REG_ADDR   = 32'h0000_0040,
  parameter logic [31:0] DATA_PORT_ADDR = 32'h0000_0044,
  parameter logic [31:0] REG_BASE       = 32'h0009_0000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlT                    ctl,
  input  logic [3:0]             step,
  input  logic                   reqRead,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [4*WORD_W-1:0]    reqWrData,
  input  logic [WORD_W-1:0]      busRdata,
  output logic                   isRead,
  output logic                   winMatch,
  output logic                   winLast,
  output logic                   busyBit,
  output logic                   pollLast,
  output logic                   busEn,
  output logic                   busWe,
  output logic [31:0]            busAddr,
  output logic [WORD_W-1:0]      busWdata,
  output logic [4*WORD_W-1:0]    rdData,
  output logic                   err,
  output logic [3:0]             stepCode,
  output logic                   recoveryReq
);

  localparam int NWORDS = 4;
  localparam int TRY_W  = $clog2(WIN_TRIES + 1);
  localparam int POLL_W = $clog2(POLL_TRIES + 1);
  localparam logic [31:0] R_ALO  = REG_BASE;
  localparam logic [31:0] R_AHI  = REG_BASE + 32'h4;
  localparam logic [31:0] R_CTRL = REG_BASE + 32'h8;
  localparam logic [31:0] R_WD0  = REG_BASE + 32'h10;
  localparam logic [31:0] R_RD0  = REG_BASE + 32'h20;
  localparam logic [WORD_W-1:0] CMD_ARM  = WORD_W'(32'h2);
  localparam logic [WORD_W-1:0] CMD_WR   = WORD_W'(32'h7);
  localparam logic [WORD_W-1:0] CMD_RD   = WORD_W'(32'h3);

  logic [ADDR_W-1:0]   addrQ;
  logic [4*WORD_W-1:0] wrQ;
  logic [TRY_W-1:0]    tryCnt;
  logic [POLL_W-1:0]   pollCnt;
  logic [31:0]         target;
  logic [WORD_W-1:0]   value;
  logic [1:0]          wIdx, rIdx;
  logic [WORD_W-1:0]   rdWord [NWORDS];

  assign wIdx = step[1:0];
  assign rIdx = 2'(step + 4'd1);

  // indirect register targeted by the current step, and the value it takes
  always_comb begin
    target = R_CTRL;
    value  = '0;
    case (step)
      STEP_ALO:  begin target = R_ALO; value = addrQ[WORD_W-1:0]; end
      STEP_AHI:  begin target = R_AHI; value = addrQ[2*WORD_W-1:WORD_W]; end
      STEP_ARM:  value = CMD_ARM;
      STEP_GOWR: value = CMD_WR;
      STEP_GORD: value = CMD_RD;
      4'd4, 4'd5, 4'd6, STEP_WD3: begin
        target = R_WD0 + {28'd0, wIdx, 2'b00};
        value  = wrQ[wIdx*WORD_W +: WORD_W];
      end
      STEP_RD0, 4'd12, 4'd13, STEP_RD3:
        target = R_RD0 + {28'd0, rIdx, 2'b00};
      default: ;
    endcase
  end

  assign busEn    = ctl.busEn;
  assign busWe    = ctl.busWrite;
  assign busAddr  = ctl.busWin ? WIN_REG_ADDR : DATA_PORT_ADDR;
  assign busWdata = ctl.busWin ? WORD_W'(target) : value;

  assign winMatch = (busRdata == WORD_W'(target));
  assign winLast  = (tryCnt == TRY_W'(WIN_TRIES - 1));
  assign busyBit  = busRdata[BUSY_BIT];
  assign pollLast = (pollCnt == POLL_W'(POLL_TRIES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wrQ    <= '0;
      isRead <= 1'b0;
    end else if (ctl.loadReq) begin
      addrQ  <= reqAddr;
      wrQ    <= reqWrData;
      isRead <= reqRead;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrTry) tryCnt <= '0;
    else if (ctl.incTry)     tryCnt <= tryCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrPoll) pollCnt <= '0;
    else if (ctl.incPoll)     pollCnt <= pollCnt + 1'b1;
  end

  generate
    for (genvar g = 0; g < NWORDS; g++) begin : g_rdWord
      always_ff @(posedge clk) begin
        if (!rstN)                                rdWord[g] <= '0;
        else if (ctl.capWord && rIdx == 2'(g))    rdWord[g] <= busRdata;
      end
      assign rdData[g*WORD_W +: WORD_W] = rdWord[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      err         <= 1'b0;
      stepCode    <= STEP_NONE;
      recoveryReq <= 1'b0;
    end else if (ctl.loadReq) begin
      err      <= 1'b0;
      stepCode <= STEP_NONE;
    end else if (ctl.finish && ctl.failed) begin
      err         <= 1'b1;
      stepCode    <= ctl.failCode;
      recoveryReq <= 1'b1;
    end
  end

endmodule

// File: rtl/wmem_seq.sv
module wmem_seq
  import wmem_pkg::*;
#(
  parameter int          WIN_TRIES      = 100,
  parameter int          POLL_TRIES     = 100,
  parameter logic [31:0] WIN_REG_ADDR   = 32'h0000_0040,
  parameter logic [31:0] DATA_PORT_ADDR = 32'h0000_0044,
  parameter logic [31:0] REG_BASE       = 32'h0009_0000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         reqRead,
  input  logic [63:0]  reqAddr,
  input  logic [127:0] reqWrData,
  output logic         idle,
  output logic         done,
  output logic         err,
  output logic [3:0]   stepCode,
  output logic         recoveryReq,
  output logic [127:0] rdData,
  output logic         busEn,
  output logic         busWe,
  output logic [31:0]  busAddr,
  output logic [31:0]  busWdata,
  input  logic [31:0]  busRdata
);

  ctlT        ctl;
  logic [3:0] step;
  logic       isRead, winMatch, winLast, busyBit, pollLast;

  wmem_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isRead(isRead),
    .winMatch(winMatch), .winLast(winLast), .busyBit(busyBit), .pollLast(pollLast),
    .ctl(ctl), .step(step), .idle(idle), .done(done)
  );

  wmem_dpath #(
    .ADDR_W(64), .WORD_W(32), .WIN_TRIES(WIN_TRIES), .POLL_TRIES(POLL_TRIES),
    .BUSY_BIT(3), .WIN_REG_ADDR(WIN_REG_ADDR), .DATA_PORT_ADDR(DATA_PORT_ADDR),
    .REG_BASE(REG_BASE)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .step(step), .reqRead(reqRead),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .busRdata(busRdata),
    .isRead(isRead), .winMatch(winMatch), .winLast(winLast), .busyBit(busyBit),
    .pollLast(pollLast), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .rdData(rdData), .err(err), .stepCode(stepCode),
    .recoveryReq(recoveryReq)
  );

endmodule

// File: rtl/wmem_seq_chk.sv
module wmem_seq_chk #(
  parameter logic [31:0] WIN_REG_ADDR   = 32'h0000_0040,
  parameter logic [31:0] DATA_PORT_ADDR = 32'h0000_0044
) (
  input logic        clk,
  input logic        rstN,
  input logic        idle,
  input logic        done,
  input logic        err,
  input logic [3:0]  stepCode,
  input logic        recoveryReq,
  input logic        busEn,
  input logic        busWe,
  input logic [31:0] busAddr,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata
);

  logic [31:0] winVal;
  logic        pendRd, confirmed;

  // track whether the window has been read back holding the last programmed value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winVal    <= '0;
      pendRd    <= 1'b0;
      confirmed <= 1'b0;
    end else begin
      pendRd <= busEn && !busWe && (busAddr == WIN_REG_ADDR);
      if (pendRd && busRdata == winVal) confirmed <= 1'b1;
      if (busEn && busWe && busAddr == WIN_REG_ADDR) begin
        winVal    <= busWdata;
        confirmed <= 1'b0;
      end
      if (busEn && busAddr == DATA_PORT_ADDR) confirmed <= 1'b0;
    end
  end

  a_r1_window_confirmed: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && busAddr == DATA_PORT_ADDR) |-> confirmed);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_code_matches_err: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (err == (stepCode != 4'd0)));

  a_r2_fail_sets_recovery: assert property (@(posedge clk) disable iff (!rstN)
    (done && err) |-> recoveryReq);

  a_r8_recovery_sticky: assert property (@(posedge clk) disable iff (!rstN)
    recoveryReq |=> recoveryReq);

  a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !busEn);

endmodule

bind wmem_seq wmem_seq_chk #(
  .WIN_REG_ADDR(WIN_REG_ADDR), .DATA_PORT_ADDR(DATA_PORT_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .idle(idle), .done(done), .err(err),
  .stepCode(stepCode), .recoveryReq(recoveryReq), .busEn(busEn), .busWe(busWe),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
);

// File: tb/wmem_seq_tb.sv
module wmem_seq_tb;

  localparam logic [31:0] WIN  = 32'h0000_0040;
  localparam logic [31:0] DP   = 32'h0000_0044;
  localparam logic [31:0] BASE = 32'h0009_0000;
  localparam logic [31:0] T_LO = BASE, T_HI = BASE + 32'h4, T_CT = BASE + 32'h8;
  localparam logic [31:0] T_WD = BASE + 32'h10, T_RD = BASE + 32'h20;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, reqRead = 1'b0;
  logic [63:0] reqAddr = '0;
  logic [127:0] reqWrData = '0;
  logic idle, done, err, recoveryReq, busEn, busWe;
  logic [3:0] stepCode;
  logic [127:0] rdData;
  logic [31:0] busAddr, busWdata;
  logic [31:0] busRdata = '0;

  always #10 clk = ~clk;

  wmem_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .reqRead(reqRead), .reqAddr(reqAddr),
    .reqWrData(reqWrData), .idle(idle), .done(done), .err(err), .stepCode(stepCode),
    .recoveryReq(recoveryReq), .rdData(rdData), .busEn(busEn), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  // ---------------- register bank and memory model ----------------
  int lag = 0, polls = 0, stuckIdx = 0;
  int winWrites = 0, winReads = 0, busyLeft = 0;
  logic winBad = 1'b0;
  logic [31:0] winTgt = '0, aLo = '0, aHi = '0;
  logic [31:0] wd [4];
  logic [31:0] rdr [4];
  logic [127:0] mem [logic [63:0]];
  logic [31:0] wrLog [32];
  logic [31:0] ctLog [8];
  logic [31:0] rdLog [256];
  int wrN = 0, ctN = 0, rdN = 0;

  always @(posedge clk) begin
    if (start && idle && rstN) begin
      winWrites = 0; wrN = 0; ctN = 0; rdN = 0;
    end
    if (busEn) begin
      if (busWe && busAddr == WIN) begin
        winTgt = busWdata; winReads = 0; winWrites++;
        winBad = (stuckIdx != 0) && (winWrites == stuckIdx);
      end else if (busWe && busAddr == DP) begin
        if (wrN < 32) wrLog[wrN] = winTgt;
        wrN++;
        if (winTgt == T_LO) aLo = busWdata;
        else if (winTgt == T_HI) aHi = busWdata;
        else if (winTgt == T_CT) begin
          if (ctN < 8) ctLog[ctN] = busWdata;
          ctN++;
          if (busWdata == 32'h7) begin
            mem[{aHi, aLo}] = {wd[3], wd[2], wd[1], wd[0]};
            busyLeft = polls;
          end else if (busWdata == 32'h3) begin
            {rdr[3], rdr[2], rdr[1], rdr[0]} = mem.exists({aHi, aLo}) ? mem[{aHi, aLo}] : 128'd0;
            busyLeft = polls;
          end
        end else begin
          for (int i = 0; i < 4; i++) if (winTgt == T_WD + 32'(4 * i)) wd[i] = busWdata;
        end
      end else if (!busWe && busAddr == WIN) begin
        winReads++;
        busRdata <= (winBad || winReads <= lag) ? ~winTgt : winTgt;
      end else if (!busWe && busAddr == DP) begin
        if (rdN < 256) rdLog[rdN] = winTgt;
        rdN++;
        if (winTgt == T_CT) begin
          if (busyLeft > 0) begin busyLeft--; busRdata <= 32'h8; end
          else busRdata <= 32'h0;
        end else begin
          busRdata <= 32'h0;
          for (int i = 0; i < 4; i++) if (winTgt == T_RD + 32'(4 * i)) busRdata <= rdr[i];
        end
      end
    end
  end

  // ---------------- checking ----------------
  int nTests = 0, nFail = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runTxn(input logic rd, input logic [63:0] a, input logic [127:0] d,
                        input int lg, input int pl, input int st);
    @(negedge clk);
    lag = lg; polls = pl; stuckIdx = st;
    reqRead = rd; reqAddr = a; reqWrData = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 40000 && !done; k++) @(negedge clk);
  endtask

  typedef struct packed {
    logic         rd;
    logic [63:0]  addr;
    logic [127:0] data;
    logic [7:0]   lag;
    logic [7:0]   polls;
    logic [7:0]   stuck;
    logic         expErr;
    logic [3:0]   expStep;
  } vecT;

  localparam logic [63:0] A1 = 64'h1234_5678_0000_0040, A2 = 64'h0000_0001_FFFF_FFF0;
  localparam logic [63:0] A3 = 64'hDEAD_0000_0000_1000, A4 = 64'h0000_00AB_0000_0200;
  localparam logic [127:0] D1 = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
  localparam logic [127:0] D2 = 128'hCAFEBABE_DEADBEEF_A5A5A5A5_5A5A5A5A;
  localparam logic [127:0] D3 = 128'h11111111_22222222_33333333_44444444;
  localparam logic [127:0] D4 = 128'h80000001_7FFFFFFE_00000000_FFFFFFFF;

  localparam vecT VECS [14] = '{
    '{1'b0, A1, D1, 8'd0, 8'd0,   8'd0, 1'b0, 4'd0},
    '{1'b1, A1, D1, 8'd0, 8'd0,   8'd0, 1'b0, 4'd0},
    '{1'b0, A2, D2, 8'd3, 8'd5,   8'd0, 1'b0, 4'd0},
    '{1'b1, A2, D2, 8'd2, 8'd7,   8'd0, 1'b0, 4'd0},
    '{1'b1, A3, '0, 8'd0, 8'd1,   8'd0, 1'b0, 4'd0},
    '{1'b0, A1, D3, 8'd0, 8'd0,   8'd4, 1'b1, 4'd4},
    '{1'b1, A1, D1, 8'd1, 8'd0,   8'd0, 1'b0, 4'd0},
    '{1'b1, A1, D1, 8'd0, 8'd0,   8'd7, 1'b1, 4'd12},
    '{1'b0, A2, D3, 8'd0, 8'd0,   8'd1, 1'b1, 4'd1},
    '{1'b0, A2, D3, 8'd0, 8'd0,   8'd8, 1'b1, 4'd8},
    '{1'b1, A2, D2, 8'd0, 8'd0,   8'd4, 1'b1, 4'd9},
    '{1'b1, A2, D2, 8'd0, 8'd0,   8'd5, 1'b1, 4'd10},
    '{1'b0, A4, D4, 8'd0, 8'd100, 8'd0, 1'b1, 4'd15},
    '{1'b1, A4, D4, 8'd0, 8'd99,  8'd0, 1'b0, 4'd0}
  };

  int doneCnt;

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(idle && !done && !err && stepCode == 0 && !recoveryReq && !busEn, "R11 reset state",
          {idle, done, err, stepCode, recoveryReq, busEn}, {1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0});
    rstN = 1'b1;

    foreach (VECS[i]) begin
      runTxn(VECS[i].rd, VECS[i].addr, VECS[i].data, int'(VECS[i].lag),
             int'(VECS[i].polls), int'(VECS[i].stuck));
      check(done, "R10 done pulse seen", done, 1);
      check(err == VECS[i].expErr, "R2/R6 err flag", err, VECS[i].expErr);
      check(stepCode == VECS[i].expStep, "R7 step code", stepCode, VECS[i].expStep);
      if (VECS[i].expErr) check(recoveryReq, "R2 recovery set", recoveryReq, 1);
      if (!VECS[i].expErr && !VECS[i].rd) begin
        check(wrN == 8 && wrLog[0] == T_LO && wrLog[1] == T_HI && wrLog[2] == T_CT,
              "R3 prologue order", {wrLog[0], wrLog[1], wrLog[2]}, {T_LO, T_HI, T_CT});
        check(wrLog[3] == T_WD && wrLog[4] == T_WD + 4 && wrLog[5] == T_WD + 8 &&
              wrLog[6] == T_WD + 12 && wrLog[7] == T_CT,
              "R4 write word order", {wrLog[3], wrLog[6], wrLog[7]}, {T_WD, T_WD + 32'd12, T_CT});
        check(ctN == 2 && ctLog[0] == 2 && ctLog[1] == 7, "R4 control codes",
              {ctLog[0], ctLog[1]}, {32'd2, 32'd7});
      end
      if (!VECS[i].expErr && VECS[i].rd) begin
        check(rdData == VECS[i].data, "R5 read data", rdData, VECS[i].data);
        check(wrN == 4 && ctN == 2 && ctLog[0] == 2 && ctLog[1] == 3, "R5 control codes",
              {ctLog[0], ctLog[1]}, {32'd2, 32'd3});
        check(rdN == int'(VECS[i].polls) + 5 && rdLog[rdN-4] == T_RD && rdLog[rdN-3] == T_RD + 4 &&
              rdLog[rdN-2] == T_RD + 8 && rdLog[rdN-1] == T_RD + 12,
              "R6 poll count and R5 word order", 128'(rdN), 128'(int'(VECS[i].polls) + 5));
      end
      @(negedge clk);
      check(!done && idle, "R10 done one cycle", done, 0);
      check(stepCode == VECS[i].expStep, "R10 step code held", stepCode, VECS[i].expStep);
    end

    // R8 recovery survives successful transactions
    check(recoveryReq, "R8 recovery sticky", recoveryReq, 1);

    // R1 window boundary: 99 wrong read-backs pass, 100 fail at first access
    runTxn(1'b0, A3, D3, 99, 0, 0);
    check(!err && stepCode == 0, "R1 window 100th read matches", stepCode, 0);
    runTxn(1'b0, A3, D2, 100, 0, 0);
    check(err && stepCode == 1, "R1 R2 window exhausted", stepCode, 1);
    runTxn(1'b1, A3, '0, 0, 0, 0);
    check(rdData == D3, "R2 aborted write left memory", rdData, D3);

    // R9 start while busy is ignored
    @(negedge clk);
    lag = 0; polls = 2; stuckIdx = 0;
    reqRead = 1'b0; reqAddr = A1 + 64'h100; reqWrData = D2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    reqRead = 1'b1; reqAddr = A2 + 64'h100; reqWrData = D4; start = 1'b1;
    @(negedge clk); start = 1'b0;
    doneCnt = 0;
    for (int k = 0; k < 300; k++) begin
      if (done) doneCnt++;
      @(negedge clk);
    end
    check(doneCnt == 1 && !err, "R9 single completion", 128'(doneCnt), 1);
    runTxn(1'b1, A1 + 64'h100, '0, 0, 0, 0);
    check(rdData == D2, "R9 first request written", rdData, D2);
    runTxn(1'b1, A2 + 64'h100, '0, 0, 0, 0);
    check(rdData == 0, "R9 ignored request had no effect", rdData, 0);

    // R8 only reset clears recovery
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(!recoveryReq && idle && stepCode == 0, "R8 R11 reset clears", recoveryReq, 0);
    rstN = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule